// File: doc/BRIEF.md
# Fall-Through Handshake FIFO

This block is a first-in first-out store of 16 words of 4 bits. Its interface is a pair of handshake strobes and a pair of ready flags, with no read or write enables. A rising edge on the shift-in strobe enters the word on `din`. That word falls through the store to the output stage without further action. A rising edge on the shift-out strobe removes the word that sits at the output stage. The flag `in_ready` tells the writer that space is free. The flag `out_ready` tells the reader that the output stage holds a valid word. Both flags drop for one cycle after each transfer, so each transfer shows up as a pulse.

The design is synchronous to `clk`, and every input is sampled on its rising edge. A strobe that rises and stays high is held pending. A held shift-out takes the next word as soon as that word reaches the output stage. A held shift-in enters its word as soon as a location frees. Because of this, two instances chain for depth with no glue logic: the upstream `out_ready` drives the downstream `shift_in`, and the downstream `in_ready` drives the upstream `shift_out`. Instances can also be placed side by side for a wider word, or `WIDTH` can be set directly. Shift-in pulses that would overflow, and shift-out pulses while the store is empty, are refused and reported.

Top module: `ftf_fifo`

## Requirements
- R1: A synchronous `mrst` sampled high leaves, after that edge, `in_ready`=1, `out_ready`=0, `dout`=0, `ovf_err`=0, `udf_err`=0 and the store empty.
- R2: A word entered into an empty store appears on `dout`, with `out_ready`=1, right after the clock edge that sampled the shift-in rising edge.
- R3: Words leave in the order they entered. The fill level changes by at most one word per clock edge.
- R4: `in_ready` is 0 for the cycle after every accepted shift-in. It is 1 otherwise when fewer than 16 words are stored, and 0 while 16 words are stored.
- R5: `out_ready` is 0 for the cycle after every shift-out that removes a word. It is 1 otherwise whenever at least one word is stored, and 0 whenever the store is empty.
- R6: If `shift_out` rose earlier and is still held high when a word reaches the output stage, that word is removed on the next edge, so `out_ready` is high for exactly one cycle.
- R7: Each rising edge of `shift_out` removes at most one word. `shift_out` must go low before another word can be removed.
- R8: A shift-in rising edge sampled while 16 words are stored enters nothing and raises `ovf_err` for exactly one cycle. If `shift_in` is dropped afterwards, the stored contents are unchanged.
- R9: A shift-out rising edge sampled while the store is empty removes nothing and raises `udf_err` for exactly one cycle.
- R10: Shift-in and shift-out rising edges sampled on the same edge both take effect. The level stays the same and the order is kept.
- R11: Two instances chained (upstream `out_ready` to downstream `shift_in` and `din` from upstream `dout`, downstream `in_ready` to upstream `shift_out`) hold 32 words and deliver them in order. A 33rd shift-in raises `ovf_err` on the upstream instance.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; all inputs are sampled on its rising edge |
| mrst | input | 1 | Synchronous master reset, active high |
| shift_in | input | 1 | Shift-in strobe; a rising edge requests entry of `din` |
| shift_out | input | 1 | Shift-out strobe; a rising edge requests removal of the output word |
| din | input | WIDTH | Word to enter |
| dout | output | WIDTH | Word at the output stage |
| in_ready | output | 1 | Input side can take a word |
| out_ready | output | 1 | Output stage holds a valid word |
| ovf_err | output | 1 | One-cycle pulse: shift-in refused because the store was full |
| udf_err | output | 1 | One-cycle pulse: shift-out refused because the store was empty |

## Verification
The properties assume that `mrst` is held high from the first clock edge, so that every comparison with the previous fill level starts from a known empty store. They also assume that both strobes are plain synchronous levels, driven only between clock edges. The stimulus meets both assumptions: it holds reset for several cycles before any strobe moves, it changes every input on the falling clock edge, and it separates each strobe pulse with at least one low cycle. Overflow is provoked only when the store is already full and the strobe is then dropped, so that refused words never re-enter.

// File: rtl/ftf_pkg.sv
package ftf_pkg;

    // Transfer decoded in one clock cycle: {push, pop}
    typedef enum logic [1:0] {
        OP_IDLE = 2'b00,
        OP_POP  = 2'b01,
        OP_PUSH = 2'b10,
        OP_BOTH = 2'b11
    } ftf_op_e;

endpackage

// File: rtl/ftf_edge.sv
// Rising-edge detector for a synchronously sampled strobe.
module ftf_edge (
    input  logic clk,
    input  logic mrst,
    input  logic lvl,
    output logic rise
);
    logic prev_d, prev_q;

    always_comb begin
        prev_d = mrst ? 1'b0 : lvl;
    end

    always_ff @(posedge clk) begin
        prev_q <= prev_d;
    end

    assign rise = lvl & ~prev_q;
endmodule

// File: rtl/ftf_store.sv
// Word storage: one synchronous write port, one combinational read port.
module ftf_store #(
    parameter int WIDTH = 4,
    parameter int DEPTH = 16,
    parameter int AW    = 4
) (
    input  logic             clk,
    input  logic             we,
    input  logic [AW-1:0]    waddr,
    input  logic [WIDTH-1:0] wdata,
    input  logic [AW-1:0]    raddr,
    output logic [WIDTH-1:0] rdata
);
    logic [WIDTH-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
    end

    assign rdata = mem[raddr];
endmodule

// File: rtl/ftf_fifo.sv
module ftf_fifo #(
    parameter int WIDTH = 4,
    parameter int DEPTH = 16
) (
    input  logic             clk,
    input  logic             mrst,
    input  logic             shift_in,
    input  logic             shift_out,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout,
    output logic             in_ready,
    output logic             out_ready,
    output logic             ovf_err,
    output logic             udf_err
);
    import ftf_pkg::*;

    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);
    localparam logic [CW-1:0] FULL_LVL = CW'(DEPTH);
    localparam logic [AW-1:0] LAST_PTR = AW'(DEPTH - 1);

    typedef struct packed {
        logic [CW-1:0]    level;
        logic [AW-1:0]    wptr;
        logic [AW-1:0]    rptr;
        logic [WIDTH-1:0] data;
        logic             iready;
        logic             oready;
        logic             si_hold;
        logic             so_hold;
        logic             ovf;
        logic             udf;
    } state_t;

    function automatic logic [AW-1:0] ptr_step(input logic [AW-1:0] p);
        return (p == LAST_PTR) ? '0 : p + 1'b1;
    endfunction

    state_t st_d, st_q;

    logic             si_rise, so_rise;
    logic             si_eff, so_eff;
    logic             do_push, do_pop;
    logic [AW-1:0]    rptr_nxt;
    logic [WIDTH-1:0] head_word;
    logic [CW-1:0]    fill_level;
    ftf_op_e          op;

    ftf_edge u_si_edge (.clk(clk), .mrst(mrst), .lvl(shift_in),  .rise(si_rise));
    ftf_edge u_so_edge (.clk(clk), .mrst(mrst), .lvl(shift_out), .rise(so_rise));

    // Transfer decode: a strobe stays pending while held high
    always_comb begin
        si_eff   = shift_in  & (si_rise | st_q.si_hold);
        so_eff   = shift_out & (so_rise | st_q.so_hold);
        do_push  = si_eff & (st_q.level != FULL_LVL);
        do_pop   = so_eff & st_q.oready;
        rptr_nxt = do_pop ? ptr_step(st_q.rptr) : st_q.rptr;
        op       = ftf_op_e'({do_push, do_pop});
    end

    ftf_store #(.WIDTH(WIDTH), .DEPTH(DEPTH), .AW(AW)) u_store (
        .clk   (clk),
        .we    (do_push),
        .waddr (st_q.wptr),
        .wdata (din),
        .raddr (rptr_nxt),
        .rdata (head_word)
    );

    // Next-state computation
    always_comb begin
        st_d = st_q;
        unique case (op)
            OP_PUSH: begin
                st_d.level = st_q.level + 1'b1;
                st_d.wptr  = ptr_step(st_q.wptr);
            end
            OP_POP: begin
                st_d.level = st_q.level - 1'b1;
            end
            OP_BOTH: begin
                st_d.wptr  = ptr_step(st_q.wptr);
            end
            default: ;
        endcase
        st_d.rptr    = rptr_nxt;
        st_d.si_hold = si_eff & ~do_push;
        st_d.so_hold = so_eff & ~do_pop;
        st_d.ovf     = si_rise & (st_q.level == FULL_LVL);
        st_d.udf     = so_rise & (st_q.level == '0);
        st_d.iready  = do_push ? 1'b0 : (st_d.level != FULL_LVL);
        st_d.oready  = do_pop  ? 1'b0 : (st_d.level != '0);
        // Output stage looks ahead to the head after this edge
        if (st_d.level != '0) begin
            st_d.data = (do_push && (rptr_nxt == st_q.wptr)) ? din : head_word;
        end
        if (mrst) begin
            st_d        = '0;
            st_d.iready = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign dout       = st_q.data;
    assign in_ready   = st_q.iready;
    assign out_ready  = st_q.oready;
    assign ovf_err    = st_q.ovf;
    assign udf_err    = st_q.udf;
    assign fill_level = st_q.level;
endmodule

// File: rtl/ftf_fifo_chk.sv
module ftf_fifo_chk #(
    parameter int WIDTH = 4,
    parameter int DEPTH = 16,
    parameter int CW    = 5
) (
    input logic             clk,
    input logic             mrst,
    input logic [WIDTH-1:0] dout,
    input logic             in_ready,
    input logic             out_ready,
    input logic             ovf_err,
    input logic             udf_err,
    input logic [CW-1:0]    level
);
    localparam logic [CW-1:0] FULL_LVL = CW'(DEPTH);

    assert_reset_state_R1: assert property (@(posedge clk)
        mrst |=> (in_ready && !out_ready && (dout == '0) && !ovf_err && !udf_err));

    assert_full_drops_dir_R4: assert property (@(posedge clk) disable iff (mrst)
        (level == FULL_LVL) |-> !in_ready);

    assert_empty_drops_dor_R5: assert property (@(posedge clk) disable iff (mrst)
        (level == '0) |-> !out_ready);

    assert_level_step_R3: assert property (@(posedge clk) disable iff (mrst)
        ((int'(level) <= int'($past(level)) + 1) && (int'(level) + 1 >= int'($past(level)))));

    assert_no_overflow_R8: assert property (@(posedge clk) disable iff (mrst)
        ovf_err |-> ($past(level) == FULL_LVL));

    assert_underflow_empty_R9: assert property (@(posedge clk) disable iff (mrst)
        udf_err |-> ($past(level) == '0));

    assert_ovf_single_R8: assert property (@(posedge clk) disable iff (mrst)
        ovf_err |=> !ovf_err);

    assert_udf_single_R9: assert property (@(posedge clk) disable iff (mrst)
        udf_err |=> !udf_err);
endmodule

bind ftf_fifo ftf_fifo_chk #(.WIDTH(WIDTH), .DEPTH(DEPTH), .CW(CW)) u_chk (
    .clk       (clk),
    .mrst      (mrst),
    .dout      (dout),
    .in_ready  (in_ready),
    .out_ready (out_ready),
    .ovf_err   (ovf_err),
    .udf_err   (udf_err),
    .level     (fill_level)
);

// File: tb/sim_ftf_fifo.sv
module sim_ftf_fifo;
    logic       clk = 1'b0;
    logic       mrst = 1'b1;
    logic       si = 1'b0, so = 1'b0;
    logic [3:0] din = '0;
    logic [3:0] dout;
    logic       in_ready, out_ready, ovf_err, udf_err;

    // chained pair
    logic       c_si = 1'b0, c_so = 1'b0;
    logic [3:0] c_din = '0;
    logic [3:0] a_dout, b_dout;
    logic       a_ir, a_or, a_ovf, a_udf;
    logic       b_ir, b_or, b_ovf, b_udf;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    ftf_fifo u0 (
        .clk(clk), .mrst(mrst), .shift_in(si), .shift_out(so), .din(din),
        .dout(dout), .in_ready(in_ready), .out_ready(out_ready),
        .ovf_err(ovf_err), .udf_err(udf_err)
    );

    ftf_fifo u_up (
        .clk(clk), .mrst(mrst), .shift_in(c_si), .shift_out(b_ir), .din(c_din),
        .dout(a_dout), .in_ready(a_ir), .out_ready(a_or),
        .ovf_err(a_ovf), .udf_err(a_udf)
    );

    ftf_fifo u_dn (
        .clk(clk), .mrst(mrst), .shift_in(a_or), .shift_out(c_so), .din(a_dout),
        .dout(b_dout), .in_ready(b_ir), .out_ready(b_or),
        .ovf_err(b_ovf), .udf_err(b_udf)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic push(input logic [3:0] v);
        din = v; si = 1'b1; tick();
        si = 1'b0; tick();
    endtask

    task automatic pop_expect(input logic [3:0] v, input int remaining);
        chk("R3", "dout before shift-out", int'(dout), int'(v));
        chk("R5", "out_ready before shift-out", int'(out_ready), 1);
        so = 1'b1; tick();
        chk("R5", "out_ready after shift-out", int'(out_ready), 0);
        so = 1'b0; tick();
        chk("R5", "out_ready recovers", int'(out_ready), (remaining > 0) ? 1 : 0);
    endtask

    task automatic t_reset();
        repeat (3) tick();
        chk("R1", "in_ready in reset", int'(in_ready), 1);
        chk("R1", "out_ready in reset", int'(out_ready), 0);
        chk("R1", "dout in reset", int'(dout), 0);
        chk("R1", "errors in reset", int'(ovf_err | udf_err), 0);
        mrst = 1'b0; tick();
    endtask

    task automatic t_fall_through();
        din = 4'hA; si = 1'b1; tick();
        chk("R2", "out_ready after entry", int'(out_ready), 1);
        chk("R2", "dout after entry", int'(dout), 10);
        chk("R4", "in_ready low after entry", int'(in_ready), 0);
        si = 1'b0; tick();
        chk("R4", "in_ready back high", int'(in_ready), 1);
        pop_expect(4'hA, 0);
    endtask

    task automatic t_order();
        logic [3:0] vals [5] = '{4'h3, 4'h9, 4'hC, 4'h5, 4'hE};
        for (int i = 0; i < 5; i++) push(vals[i]);
        for (int i = 0; i < 5; i++) pop_expect(vals[i], 4 - i);
    endtask

    task automatic t_full_overflow();
        for (int i = 0; i < 16; i++) push(4'((i * 7 + 1) & 15));
        chk("R4", "in_ready while full", int'(in_ready), 0);
        din = 4'h0; si = 1'b1; tick();
        chk("R8", "ovf_err pulse", int'(ovf_err), 1);
        si = 1'b0; tick();
        chk("R8", "ovf_err clears", int'(ovf_err), 0);
        chk("R4", "in_ready still low", int'(in_ready), 0);
        for (int i = 0; i < 16; i++) begin
            pop_expect(4'((i * 7 + 1) & 15), 15 - i);
            if (i == 0) chk("R4", "in_ready after leaving full", int'(in_ready), 1);
        end
    endtask

    task automatic t_underflow();
        so = 1'b1; tick();
        chk("R9", "udf_err pulse", int'(udf_err), 1);
        chk("R9", "out_ready stays low", int'(out_ready), 0);
        chk("R9", "in_ready stays high", int'(in_ready), 1);
        so = 1'b0; tick();
        chk("R9", "udf_err clears", int'(udf_err), 0);
    endtask

    task automatic t_held_out();
        so = 1'b1; tick();
        chk("R9", "udf_err on empty arm", int'(udf_err), 1);
        din = 4'h6; si = 1'b1; tick();
        chk("R6", "out_ready on arrival", int'(out_ready), 1);
        chk("R6", "dout on arrival", int'(dout), 6);
        si = 1'b0; tick();
        chk("R6", "word taken by held shift-out", int'(out_ready), 0);
        din = 4'hB; si = 1'b1; tick();
        chk("R7", "second word arrives", int'(out_ready), 1);
        si = 1'b0; tick();
        chk("R7", "held shift-out takes no second word", int'(out_ready), 1);
        tick();
        chk("R7", "second word still present", int'(dout), 11);
        so = 1'b0; tick();
        pop_expect(4'hB, 0);
    endtask

    task automatic t_simultaneous();
        push(4'h1); push(4'h2); push(4'h3);
        din = 4'h4; si = 1'b1; so = 1'b1; tick();
        chk("R10", "out_ready low after both", int'(out_ready), 0);
        chk("R10", "in_ready low after both", int'(in_ready), 0);
        si = 1'b0; so = 1'b0; tick();
        chk("R10", "next head", int'(dout), 2);
        pop_expect(4'h2, 2);
        pop_expect(4'h3, 1);
        pop_expect(4'h4, 0);
    endtask

    task automatic t_chain();
        for (int i = 0; i < 32; i++) begin
            c_din = 4'((i * 5 + 3) & 15); c_si = 1'b1; tick();
            c_si = 1'b0; tick();
        end
        repeat (100) tick();
        chk("R11", "upstream full", int'(a_ir), 0);
        chk("R11", "downstream full", int'(b_ir), 0);
        chk("R11", "downstream head", int'(b_dout), 3);
        c_din = 4'hF; c_si = 1'b1; tick();
        chk("R11", "33rd word overflows", int'(a_ovf), 1);
        c_si = 1'b0; tick();
        for (int i = 0; i < 32; i++) begin
            for (int w = 0; w < 20 && !b_or; w++) tick();
            chk("R11", "chain order", int'(b_dout), (i * 5 + 3) & 15);
            c_so = 1'b1; tick();
            c_so = 1'b0; tick();
        end
        repeat (20) tick();
        chk("R11", "chain drained down", int'(b_or), 0);
        chk("R11", "chain drained up", int'(a_or), 0);
    endtask

    initial begin
        tick();
        t_reset();
        t_fall_through();
        t_order();
        t_full_overflow();
        t_underflow();
        t_held_out();
        t_simultaneous();
        t_chain();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule